// File: doc/BRIEF.md
# Parallel-to-Serial Transmit Serializer

This block turns a parallel word produced in a slow core clock domain into a serial bit stream for a differential output driver. A holding register captures the word on every core clock edge. In the fast serial clock domain, a one-cycle load strobe copies the held word into a shift register. That register then empties on the fast clock, most significant bit first. The word width equals the serialization factor, which is a parameter of at most 10.

A run-time lane-mode input selects the output path. In single-rate mode one bit leaves per fast cycle on the upper lane, and the lower lane stays low. In double-rate mode the shift register moves two places per fast cycle and shows the pair on both lanes, with the earlier bit on the upper lane. In that mode a word leaves in half as many cycles, so the factor must be even. The core and fast clocks are assumed frequency-locked, and the strobe generator outside the block pulses once per word period: every FACTOR fast cycles in single-rate mode, every FACTOR/2 in double-rate mode.

An output-enable input is registered on the fast clock and produces a drive-enable signal for the pad buffer, which sits outside the block. While the driver is disabled, both data lanes are held low, but shifting goes on internally.

Top module: `sertx_top`

## Requirements
- R1: On each rising core clock edge, the holding register takes `par_data`, and synchronous reset clears it. The shift register is always loaded from this held value, never from the live input.
- R2: When `load_stb` is high at a rising fast clock edge, the shift register takes the held word, and shifting is suppressed at that edge.
- R3: In the fast cycle after a load edge, `ser_out[1]` carries bit FACTOR-1 (the MSB) of the loaded word.
- R4: With `ddr_sel`=0 (single-rate), each later fast cycle brings the next lower bit onto `ser_out[1]`, and `ser_out[0]` is held 0.
- R5: With `ddr_sel`=1 (double-rate), the register advances two bits per fast cycle. Cycle k after the load shows `ser_out[1]` = bit FACTOR-1-2k and `ser_out[0]` = bit FACTOR-2-2k, so a word needs FACTOR/2 cycles.
- R6: With a strobe every FACTOR (single-rate) or FACTOR/2 (double-rate) fast cycles, consecutive words leave as one continuous stream. No bit is dropped or repeated across a word boundary.
- R7: Synchronous reset clears the shift register and the drive enable. From then until the first strobe, `ser_out` is 2'b00.
- R8: `pad_oe` follows `out_en` one fast cycle later. While `pad_oe` is 0, `ser_out` is 2'b00, yet shifting goes on, so after re-enable the output shows the bit the stream would have reached anyway.
- R9: When no new strobe arrives after a word, zeros shift in, and `ser_out` is 2'b00 once the word has left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| core_clk | input | 1 | Slow core clock for the holding register |
| fast_clk | input | 1 | Fast serial clock for shifting and output |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| par_data | input | FACTOR | Parallel word from the core |
| load_stb | input | 1 | One-cycle fast-domain strobe that loads the shift register |
| ddr_sel | input | 1 | 0 = one bit per cycle, 1 = two bits per cycle |
| out_en | input | 1 | Output enable request |
| ser_out | output | 2 | Serial lanes; [1] leads, [0] carries the second bit in double-rate mode |
| pad_oe | output | 1 | Drive enable for the differential pad buffer |

## Verification
The assertions check a set of relations on every fast or core edge:
- the holding register follows the input;
- a strobe copies the held word and puts its MSB on the upper lane;
- the shift register advances by one or two places depending on mode;
- the lower lane stays quiet in single-rate mode;
- the drive enable lags the enable request by one cycle, with both lanes low while it is off;
- the output stays low from reset until the first strobe.

Only the directed scenarios can show properties that span many cycles:
- the stream runs unbroken across back-to-back word boundaries in both modes;
- a word changed on the input after the last core edge is not the one sent;
- a disable window in mid-word leaves the bit count intact;
- the zero tail follows the last word;
- a reset in mid-word flushes the stream.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // Largest serialization factor the shift path supports.
    localparam int unsigned SER_MAX_FACTOR = 10;

    // Output lane mode: one bit or two bits per fast cycle.
    typedef enum logic {
        LANE_SDR = 1'b0,
        LANE_DDR = 1'b1
    } lane_mode_e;

    // The two leading bits of the shift register, in transmit order.
    typedef struct packed {
        logic first;
        logic second;
    } lane_pair_t;

    // Number of bit positions the shift register advances per fast cycle.
    function automatic int unsigned lane_step(lane_mode_e mode);
        return (mode == LANE_DDR) ? 2 : 1;
    endfunction

    // Fast cycles needed to send one word in the given mode.
    function automatic int unsigned word_cycles(int unsigned factor, lane_mode_e mode);
        return factor / lane_step(mode);
    endfunction

endpackage

// File: rtl/sertx_hold_reg.sv
module sertx_hold_reg #(
    parameter int unsigned WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Core-domain holding register: the word stays stable here while
    // the fast domain decides when to take it.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int unsigned FACTOR = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  lane_mode_e        mode,
    input  logic [FACTOR-1:0] word,
    output logic [FACTOR-1:0] sh_q,
    output lane_pair_t        head
);

    localparam int unsigned TOP = FACTOR - 1;

    // A load has priority over a shift at the same edge; otherwise the
    // register moves one or two places toward the MSB end, filling zeros.
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load_en) begin
            sh_q <= word;
        end else begin
            sh_q <= sh_q << lane_step(mode);
        end
    end

    assign head.first  = sh_q[TOP];
    assign head.second = sh_q[TOP-1];

endmodule

// File: rtl/sertx_out_stage.sv
module sertx_out_stage
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       out_en,
    input  lane_mode_e mode,
    input  lane_pair_t head,
    output logic [1:0] lanes,
    output logic       drive_en
);

    logic oe_q;

    // The enable is retimed onto the fast clock so the driver switches
    // only at bit boundaries.
    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= out_en;
        end
    end

    always_comb begin
        lanes = 2'b00;
        if (oe_q) begin
            lanes[1] = head.first;
            if (mode == LANE_DDR) begin
                lanes[0] = head.second;
            end
        end
    end

    assign drive_en = oe_q;

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int unsigned FACTOR = 10
) (
    input  logic              core_clk,
    input  logic              fast_clk,
    input  logic              rst,
    input  logic [FACTOR-1:0] par_data,
    input  logic              load_stb,
    input  logic              ddr_sel,
    input  logic              out_en,
    output logic [1:0]        ser_out,
    output logic              pad_oe
);

    logic [FACTOR-1:0] hold_q;
    logic [FACTOR-1:0] sh_q;
    lane_pair_t        head;
    lane_mode_e        mode;

    assign mode = ddr_sel ? LANE_DDR : LANE_SDR;

    sertx_hold_reg #(
        .WIDTH (FACTOR)
    ) hold_i (
        .clk (core_clk),
        .rst (rst),
        .d   (par_data),
        .q   (hold_q)
    );

    sertx_shifter #(
        .FACTOR (FACTOR)
    ) shift_i (
        .clk     (fast_clk),
        .rst     (rst),
        .load_en (load_stb),
        .mode    (mode),
        .word    (hold_q),
        .sh_q    (sh_q),
        .head    (head)
    );

    sertx_out_stage out_i (
        .clk      (fast_clk),
        .rst      (rst),
        .out_en   (out_en),
        .mode     (mode),
        .head     (head),
        .lanes    (ser_out),
        .drive_en (pad_oe)
    );

endmodule

// File: rtl/sertx_top_chk.sv
module sertx_top_chk #(
    parameter int unsigned FACTOR = 10
) (
    input logic              core_clk,
    input logic              fast_clk,
    input logic              rst,
    input logic [FACTOR-1:0] par_data,
    input logic              load_stb,
    input logic              ddr_sel,
    input logic              out_en,
    input logic [FACTOR-1:0] hold_q,
    input logic [FACTOR-1:0] sh_q,
    input logic [1:0]        ser_out,
    input logic              pad_oe
);

    // Tracks whether any word has been loaded since reset.
    logic seen_load;
    always_ff @(posedge fast_clk) begin
        if (rst) begin
            seen_load <= 1'b0;
        end else if (load_stb) begin
            seen_load <= 1'b1;
        end
    end

    AST_HOLD_TRACK: assert property (@(posedge core_clk) disable iff (rst)
        1'b1 |=> hold_q == $past(par_data)); // R1

    AST_LOAD_COPY: assert property (@(posedge fast_clk) disable iff (rst)
        load_stb |=> sh_q == $past(hold_q)); // R2

    AST_MSB_LEADS: assert property (@(posedge fast_clk) disable iff (rst)
        (load_stb && out_en) |=> ser_out[1] == $past(hold_q[FACTOR-1])); // R3

    AST_SDR_NEXT_BIT: assert property (@(posedge fast_clk) disable iff (rst)
        (!ddr_sel && !load_stb) |=> sh_q[FACTOR-1] == $past(sh_q[FACTOR-2])); // R4

    AST_SDR_QUIET_LANE: assert property (@(posedge fast_clk) disable iff (rst)
        !ddr_sel |-> ser_out[0] == 1'b0); // R4

    AST_DDR_NEXT_PAIR: assert property (@(posedge fast_clk) disable iff (rst)
        (ddr_sel && !load_stb) |=> sh_q[FACTOR-1 -: 2] == $past(sh_q[FACTOR-3 -: 2])); // R5

    AST_IDLE_LOW: assert property (@(posedge fast_clk) disable iff (rst)
        !seen_load |-> ser_out == 2'b00); // R7

    AST_OE_FOLLOW: assert property (@(posedge fast_clk) disable iff (rst)
        1'b1 |=> pad_oe == $past(out_en)); // R8

    AST_OFF_QUIET: assert property (@(posedge fast_clk) disable iff (rst)
        !pad_oe |-> ser_out == 2'b00); // R8

endmodule

bind sertx_top sertx_top_chk #(
    .FACTOR (FACTOR)
) chk_i (
    .core_clk (core_clk),
    .fast_clk (fast_clk),
    .rst      (rst),
    .par_data (par_data),
    .load_stb (load_stb),
    .ddr_sel  (ddr_sel),
    .out_en   (out_en),
    .hold_q   (hold_q),
    .sh_q     (sh_q),
    .ser_out  (ser_out),
    .pad_oe   (pad_oe)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

    localparam int unsigned FACTOR = 10;

    logic              core_clk = 1'b0;
    logic              fast_clk = 1'b0;
    logic              rst      = 1'b1;
    logic [FACTOR-1:0] par_data = '0;
    logic              load_stb = 1'b0;
    logic              ddr_sel  = 1'b0;
    logic              out_en   = 1'b0;
    logic [1:0]        ser_out;
    logic              pad_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // 250 MHz fast clock: rising edges at 2, 6, 10 ns ...
    always #2 fast_clk = ~fast_clk;

    // Core clock at half the fast rate; rising edges at 5, 13, 21 ns,
    // clear of every fast edge.
    initial begin
        #1;
        forever #4 core_clk = ~core_clk;
    end

    sertx_top #(.FACTOR(FACTOR)) dut_i (
        .core_clk (core_clk),
        .fast_clk (fast_clk),
        .rst      (rst),
        .par_data (par_data),
        .load_stb (load_stb),
        .ddr_sel  (ddr_sel),
        .out_en   (out_en),
        .ser_out  (ser_out),
        .pad_oe   (pad_oe)
    );

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    function automatic logic [FACTOR-1:0] mk_word(input int seed, input int w);
        int v;
        v = (seed * 173 + w * 389 + 91) ^ (w * w * 7 + seed);
        return v[FACTOR-1:0];
    endfunction

    // R7: reset state and idle output before any strobe.
    task automatic t_reset_state;
        rst = 1'b1;
        out_en = 1'b1;
        par_data = '1;
        repeat (4) @(negedge fast_clk);
        chk("R7 reset lanes", ser_out, 2'b00);
        chk("R7 reset oe", {1'b0, pad_oe}, 2'b00);
        rst = 1'b0;
        repeat (3) @(negedge fast_clk);
        chk("R7 idle lanes", ser_out, 2'b00);
        chk("R8 oe follows", {1'b0, pad_oe}, 2'b01);
        ddr_sel = 1'b1;
        repeat (2) @(negedge fast_clk);
        chk("R7 idle lanes ddr", ser_out, 2'b00);
        ddr_sel = 1'b0;
    endtask

    // R1/R2: the word loaded is the one held at the last core edge.
    task automatic t_hold_vs_live;
        logic [FACTOR-1:0] a;
        a = 10'h2C5;
        out_en = 1'b1;
        ddr_sel = 1'b0;
        @(negedge fast_clk);
        par_data = a;
        @(posedge core_clk);
        @(negedge fast_clk);
        par_data = ~a;
        load_stb = 1'b1;
        for (int j = 0; j < FACTOR; j++) begin
            @(negedge fast_clk);
            load_stb = 1'b0;
            chk(j == 0 ? "R1 held word msb" : "R2 held word bit", ser_out, {a[FACTOR-1-j], 1'b0});
        end
    endtask

    // R3..R6, R8, R9: back-to-back words, optional disable window.
    task automatic t_stream(input logic ddr, input int nwords, input int seed, input int gap_word);
        int per;
        logic [FACTOR-1:0] cur;
        per = ddr ? FACTOR / 2 : FACTOR;
        ddr_sel = ddr;
        out_en = 1'b1;
        @(negedge fast_clk);
        par_data = mk_word(seed, 0);
        repeat (5) @(negedge fast_clk);
        load_stb = 1'b1;
        for (int w = 0; w < nwords; w++) begin
            cur = mk_word(seed, w);
            for (int j = 0; j < per; j++) begin
                logic exp_oe;
                logic [1:0] exp;
                exp_oe = out_en;
                @(negedge fast_clk);
                if (j == 0) begin
                    load_stb = 1'b0;
                    par_data = mk_word(seed, w + 1);
                end
                if (ddr)
                    exp = {cur[FACTOR-1-2*j], cur[FACTOR-2-2*j]};
                else
                    exp = {cur[FACTOR-1-j], 1'b0};
                if (!exp_oe) exp = 2'b00;
                chk("R8 drive enable", {1'b0, pad_oe}, {1'b0, exp_oe});
                if (!exp_oe)
                    chk("R8 quiet while off", ser_out, exp);
                else if (j == 0 && w == 0)
                    chk("R3 first bit", ser_out, exp);
                else if (j == 0)
                    chk("R6 word boundary", ser_out, exp);
                else if (ddr)
                    chk("R5 ddr pair", ser_out, exp);
                else
                    chk("R4 sdr bit", ser_out, exp);
                if (w == gap_word && j == 1) out_en = 1'b0;
                if (w == gap_word && j == 2) out_en = 1'b1;
                if (j == per - 1 && w < nwords - 1) load_stb = 1'b1;
            end
        end
        for (int k = 0; k < FACTOR; k++) begin
            @(negedge fast_clk);
            chk("R9 zero tail", ser_out, 2'b00);
        end
    endtask

    // R7: reset in mid-word flushes the stream.
    task automatic t_reset_mid;
        ddr_sel = 1'b0;
        out_en = 1'b1;
        @(negedge fast_clk);
        par_data = '1;
        repeat (4) @(negedge fast_clk);
        load_stb = 1'b1;
        @(negedge fast_clk);
        load_stb = 1'b0;
        chk("R3 all-ones msb", ser_out, 2'b10);
        repeat (2) @(negedge fast_clk);
        rst = 1'b1;
        @(negedge fast_clk);
        chk("R7 mid-word reset lanes", ser_out, 2'b00);
        chk("R7 mid-word reset oe", {1'b0, pad_oe}, 2'b00);
        repeat (3) @(negedge fast_clk);
        rst = 1'b0;
        repeat (4) @(negedge fast_clk);
        chk("R7 flushed after reset", ser_out, 2'b00);
        chk("R8 oe back", {1'b0, pad_oe}, 2'b01);
    endtask

    initial begin
        t_reset_state();
        t_hold_vs_live();
        t_stream(1'b0, 4, 3, -1);
        t_stream(1'b1, 4, 11, -1);
        t_stream(1'b0, 3, 21, 1);
        t_stream(1'b1, 3, 42, 2);
        t_reset_mid();
        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            report();
            $finish;
        end
    end

endmodule